// File: doc/BRIEF.md
# Burst Frame Transmitter with Scrambler

This block sends the outgoing half of a ping-pong burst link for a two-wire 2B+D subscriber line. Once per burst repetition period an external strobe starts a new burst. The burst is 37 bits long and is clocked out one bit per bit-rate enable, which sets the 384 kbit/s burst rate. The block takes sixteen B1 bits, sixteen B2 bits and four D bits from a parallel holding interface, together with a valid flag, and captures them at the start strobe. It scrambles every user bit with a self-synchronizing nine-stage scrambler. It puts an unscrambled framing bit of value 1 in front of them and drives each line bit as a ternary AMI symbol.

The surrounding logic gives the start strobe every 250 µs and keeps the holding interface loaded. The block reports `busy_o` while a burst is in flight. It pulses `data_taken_o` when it has captured valid channel data. A strobe that arrives too early is dropped and sets a sticky `overrun_o` flag, which only reset clears. The scrambler history and the AMI polarity both carry over from one burst to the next.

Top module: `burst_tx`

## Requirements
- R1: After reset, `sym_o` is 2'b00 and `busy_o`, `overrun_o` and `data_taken_o` are all 0.
- R2: A `frame_start_i` sampled high while `busy_o` is 0 sets `busy_o` on the next clock. The first symbol appears after the next clock edge on which `bit_en_i` is high, and this holds even when that enable falls in the same cycle as the strobe. After that, each `bit_en_i` edge gives one new symbol, for exactly 37 symbols. The `bit_en_i` edge that follows the 37th symbol sets `sym_o` to 2'b00 and clears `busy_o`.
- R3: Bit 0 of every burst is the framing bit. It is always 1 and is sent unscrambled. It does not advance the scrambler.
- R4: After the framing bit the user bits go out in this order: B1[15:8], B2[15:8], D[3:2], B1[7:0], B2[7:0], D[1:0]. Each field is sent MSB first.
- R5: Each user bit u goes out as s = u XOR h5 XOR h9. Here hk is the k-th most recent scrambled user bit sent (h1 is the newest). The history is all zeros after reset and carries over from one burst to the next.
- R6: AMI coding. A 0 bit is sent as 2'b00 and a 1 bit as 2'b01 (positive) or 2'b11 (negative). Successive 1 bits alternate in polarity. This includes framing bits, and the alternation continues across bursts. The first 1 after reset is positive. The code 2'b10 never appears.
- R7: `sym_o` changes only on a clock edge where `bit_en_i` was high, and it is 2'b00 whenever `busy_o` is 0.
- R8: A `frame_start_i` sampled while `busy_o` is 1 has no effect on the burst or on the captured data. This includes the cycle in which the burst ends. Such a strobe sets `overrun_o`, which stays 1 until reset.
- R9: If an accepted start strobe sees `data_valid_i` high, the block captures the channel inputs and pulses `data_taken_o` for one cycle. If `data_valid_i` is low, every user bit is taken as 1 before scrambling and `data_taken_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-cycle enable at the burst bit rate |
| frame_start_i | input | 1 | Burst start strobe |
| data_valid_i | input | 1 | Channel inputs hold fresh data |
| b1_i | input | 16 | B1 channel bits for one burst |
| b2_i | input | 16 | B2 channel bits for one burst |
| d_i | input | 4 | D channel bits for one burst |
| sym_o | output | 2 | AMI symbol: 00 zero, 01 positive, 11 negative |
| busy_o | output | 1 | Burst in progress |
| data_taken_o | output | 1 | Valid channel data captured (one-cycle pulse) |
| overrun_o | output | 1 | Sticky flag: start strobe arrived while busy |

## Verification
Two events can fall in the same cycle. The first is the `bit_en_i` edge that ends a burst, which happens together with a new start strobe. The bench times the strobe from its model so that it lands on that exact enable, and it expects the strobe to be dropped and counted as an overrun. The second is a start strobe that coincides with a bit enable while the block is idle. Here the strobe must be accepted, and the first symbol must wait for the following enable. In both cases the reference model predicts every symbol, busy, overrun and capture value on each clock, and the bench compares them with the outputs.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_POS  = 2'b01,
    SYM_NEG  = 2'b11
  } sym_e;
endpackage

// File: rtl/burst_framer.sv
module burst_framer #(
  parameter int CH_BITS = 8,
  parameter int D_BITS  = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   bit_en_i,
  input  logic                   start_i,
  input  logic                   valid_i,
  input  logic [2*CH_BITS-1:0]   b1_i,
  input  logic [2*CH_BITS-1:0]   b2_i,
  input  logic [2*D_BITS-1:0]    d_i,
  output logic                   busy_o,
  output logic                   adv_o,
  output logic                   fin_o,
  output logic                   user_o,
  output logic                   raw_o,
  output logic                   taken_o,
  output logic                   ovr_o
);
  localparam int HALF  = 2*CH_BITS + D_BITS;
  localparam int PAY   = 2*HALF;
  localparam int FRAME = PAY + 1;
  localparam int CW    = $clog2(FRAME + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME);

  logic [CW-1:0]  cnt_q;
  logic [PAY-1:0] pay_q;
  logic [PAY-1:0] ordered;
  logic           start_ok;
  logic           stepping;

  assign ordered = {b1_i[2*CH_BITS-1 -: CH_BITS], b2_i[2*CH_BITS-1 -: CH_BITS],
                    d_i[2*D_BITS-1 -: D_BITS],
                    b1_i[CH_BITS-1:0], b2_i[CH_BITS-1:0], d_i[D_BITS-1:0]};

  assign start_ok = start_i & ~busy_o;
  assign stepping = bit_en_i & busy_o;
  assign adv_o    = stepping & (cnt_q != LAST);
  assign fin_o    = stepping & (cnt_q == LAST);
  assign user_o   = (cnt_q != '0);
  assign raw_o    = user_o ? pay_q[PAY-1] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      cnt_q   <= '0;
      pay_q   <= '0;
      taken_o <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      taken_o <= 1'b0;
      if (start_i && busy_o) ovr_o <= 1'b1;
      if (start_ok) begin
        busy_o  <= 1'b1;
        cnt_q   <= '0;
        pay_q   <= valid_i ? ordered : '1;
        taken_o <= valid_i;
      end else if (fin_o) begin
        busy_o <= 1'b0;
        cnt_q  <= '0;
      end else if (adv_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (user_o) pay_q <= {pay_q[PAY-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/burst_scrambler.sv
module burst_scrambler #(
  parameter int LEN = 9,
  parameter int TAP = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic din_i,
  output logic dout_o
);
  logic [LEN-1:0] hist_q;

  // hist_q[0] is the newest sent bit
  assign dout_o = din_i ^ hist_q[TAP-1] ^ hist_q[LEN-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hist_q <= '0;
    else if (en_i) hist_q <= {hist_q[LEN-2:0], dout_o};
  end
endmodule

// File: rtl/burst_ami_enc.sv
module burst_ami_enc
  import burst_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       fin_i,
  input  logic       bit_i,
  output logic [1:0] sym_o
);
  logic neg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_q <= 1'b0;
      sym_o <= SYM_ZERO;
    end else if (fin_i) begin
      sym_o <= SYM_ZERO;
    end else if (adv_i) begin
      if (bit_i) begin
        sym_o <= neg_q ? SYM_NEG : SYM_POS;
        neg_q <= ~neg_q;
      end else begin
        sym_o <= SYM_ZERO;
      end
    end
  end
endmodule

// File: rtl/burst_tx.sv
module burst_tx #(
  parameter int CH_BITS = 8,
  parameter int D_BITS  = 2,
  parameter int SCR_LEN = 9,
  parameter int SCR_TAP = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_en_i,
  input  logic                 frame_start_i,
  input  logic                 data_valid_i,
  input  logic [2*CH_BITS-1:0] b1_i,
  input  logic [2*CH_BITS-1:0] b2_i,
  input  logic [2*D_BITS-1:0]  d_i,
  output logic [1:0]           sym_o,
  output logic                 busy_o,
  output logic                 data_taken_o,
  output logic                 overrun_o
);
  logic adv, fin, user_bit, raw_bit, scr_bit, line_bit;

  burst_framer #(.CH_BITS(CH_BITS), .D_BITS(D_BITS)) u_framer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_en_i(bit_en_i),
    .start_i (frame_start_i),
    .valid_i (data_valid_i),
    .b1_i    (b1_i),
    .b2_i    (b2_i),
    .d_i     (d_i),
    .busy_o  (busy_o),
    .adv_o   (adv),
    .fin_o   (fin),
    .user_o  (user_bit),
    .raw_o   (raw_bit),
    .taken_o (data_taken_o),
    .ovr_o   (overrun_o)
  );

  burst_scrambler #(.LEN(SCR_LEN), .TAP(SCR_TAP)) u_scr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (adv & user_bit),
    .din_i (raw_bit),
    .dout_o(scr_bit)
  );

  // framing bit bypasses the scrambler
  assign line_bit = user_bit ? scr_bit : raw_bit;

  burst_ami_enc u_ami (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (adv),
    .fin_i (fin),
    .bit_i (line_bit),
    .sym_o (sym_o)
  );
endmodule

// File: rtl/burst_tx_chk.sv
module burst_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_en_i,
  input logic       frame_start_i,
  input logic [1:0] sym_o,
  input logic       busy_o,
  input logic       data_taken_o,
  input logic       overrun_o
);
  logic       pend_q;
  logic [1:0] last_nz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      last_nz_q <= 2'b00;
    end else begin
      pend_q <= bit_en_i & busy_o;
      if (pend_q && sym_o != 2'b00) last_nz_q <= sym_o;
    end
  end

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && !busy_o |=> busy_o);                               // R2
  AST_TAKEN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_taken_o |=> !data_taken_o);                                    // R9
  AST_AMI_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && sym_o != 2'b00 && last_nz_q != 2'b00 |-> sym_o != last_nz_q); // R6
  AST_NO_BAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_o != 2'b10);                                                    // R6
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sym_o == 2'b00);                                        // R7
  AST_SYM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(sym_o));                                      // R7
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);                                           // R8
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && busy_o |=> overrun_o);                             // R8
endmodule

bind burst_tx burst_tx_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bit_en_i     (bit_en_i),
  .frame_start_i(frame_start_i),
  .sym_o        (sym_o),
  .busy_o       (busy_o),
  .data_taken_o (data_taken_o),
  .overrun_o    (overrun_o)
);

// File: tb/sim_burst_tx.sv
`timescale 1ns/1ps
module sim_burst_tx;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_en_i = 1'b0;
  logic        frame_start_i = 1'b0;
  logic        data_valid_i = 1'b0;
  logic [15:0] b1_i = '0;
  logic [15:0] b2_i = '0;
  logic [3:0]  d_i = '0;
  logic [1:0]  sym_o;
  logic        busy_o, data_taken_o, overrun_o;

  int    checks = 0;
  int    errors = 0;
  int    div = 0;
  string cur_tag = "R1";

  // reference model state
  bit   m_q[$];
  bit   m_hist[$];
  bit   m_busy, m_neg, m_ovr, m_ack;
  logic [1:0] m_sym;

  burst_tx u0 (.*);

  always #2.5 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    div = (div + 1) % 4;
    bit_en_i = (div == 0);
  end

  task automatic m_push_user(bit u);
    bit s;
    s = u ^ m_hist[4] ^ m_hist[8];
    void'(m_hist.pop_back());
    m_hist.push_front(s);
    m_q.push_back(s);
  endtask

  task automatic m_load(bit v, logic [15:0] b1, logic [15:0] b2, logic [3:0] d);
    m_q.push_back(1'b1);
    for (int h = 1; h >= 0; h--) begin
      for (int i = 7; i >= 0; i--) m_push_user(v ? b1[h*8+i] : 1'b1);
      for (int i = 7; i >= 0; i--) m_push_user(v ? b2[h*8+i] : 1'b1);
      for (int i = 1; i >= 0; i--) m_push_user(v ? d[h*2+i] : 1'b1);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q.delete();
      m_hist.delete();
      for (int i = 0; i < 9; i++) m_hist.push_back(1'b0);
      m_busy = 0; m_neg = 0; m_ovr = 0; m_ack = 0; m_sym = 2'b00;
    end else begin
      bit was_busy;
      bit b;
      was_busy = m_busy;
      m_ack = 0;
      if (bit_en_i && was_busy) begin
        if (m_q.size() == 0) begin
          m_busy = 0;
          m_sym = 2'b00;
        end else begin
          b = m_q.pop_front();
          m_sym = b ? (m_neg ? 2'b11 : 2'b01) : 2'b00;
          if (b) m_neg = ~m_neg;
        end
      end
      if (frame_start_i) begin
        if (was_busy) m_ovr = 1;
        else begin
          m_load(data_valid_i, b1_i, b2_i, d_i);
          m_busy = 1;
          m_ack = data_valid_i;
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      checks++;
      if (sym_o !== m_sym || busy_o !== m_busy || overrun_o !== m_ovr ||
          data_taken_o !== m_ack) begin
        errors++;
        $display("FAIL %s t=%0t sym/busy/ovr/taken actual=%b/%b/%b/%b expected=%b/%b/%b/%b",
                 cur_tag, $time, sym_o, busy_o, overrun_o, data_taken_o,
                 m_sym, m_busy, m_ovr, m_ack);
      end
    end
  end

  task automatic tick();
    @(negedge clk_i); #1;
  endtask

  task automatic pulse_start(bit v, logic [15:0] b1, logic [15:0] b2, logic [3:0] d);
    data_valid_i = v; b1_i = b1; b2_i = b2; d_i = d;
    frame_start_i = 1'b1;
    tick();
    frame_start_i = 1'b0;
  endtask

  task automatic send(bit v, logic [15:0] b1, logic [15:0] b2, logic [3:0] d);
    do tick(); while (m_busy);
    pulse_start(v, b1, b2, d);
  endtask

  task automatic wait_idle();
    do tick(); while (m_busy);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) tick();
    rst_ni = 1'b1;
    // R1: reset values
    tick();
    checks++;
    if (sym_o !== 2'b00 || busy_o || overrun_o || data_taken_o) begin
      errors++;
      $display("FAIL R1 reset actual=%b/%b/%b/%b expected=00/0/0/0",
               sym_o, busy_o, overrun_o, data_taken_o);
    end
    repeat (6) tick();

    // R3: zero data leaves only the framing pulse, positive (R6)
    cur_tag = "R3";
    send(1, 16'h0000, 16'h0000, 4'h0);
    tick(); tick();
    checks++;
    if (busy_o !== 1'b1) begin
      errors++;
      $display("FAIL R2 busy after start actual=%b expected=1", busy_o);
    end
    wait_idle();

    cur_tag = "R4";
    send(1, 16'hA5C3, 16'h0F81, 4'b1001);
    cur_tag = "R5";
    send(1, 16'h1234, 16'hFEDC, 4'b0110);
    send(1, 16'h8001, 16'h7FFE, 4'b1111);
    cur_tag = "R9";
    send(0, 16'h0000, 16'h0000, 4'h0);
    cur_tag = "R6";
    send(1, 16'hFFFF, 16'hFFFF, 4'hF);
    wait_idle();

    // R8: start mid-burst is ignored
    cur_tag = "R8";
    send(1, 16'h00FF, 16'hFF00, 4'b0101);
    repeat (40) tick();
    pulse_start(1, 16'hFFFF, 16'h0000, 4'hA);
    // R8: start on the enable that ends the burst
    do tick(); while (!(m_busy && m_q.size() == 0 && bit_en_i));
    pulse_start(1, 16'h5555, 16'hAAAA, 4'h3);
    checks++;
    if (overrun_o !== 1'b1) begin
      errors++;
      $display("FAIL R8 overrun actual=%b expected=1", overrun_o);
    end
    wait_idle();

    // R2: idle start coinciding with a bit enable
    cur_tag = "R2";
    do tick(); while (!(!m_busy && bit_en_i));
    pulse_start(1, 16'hC0DE, 16'hBEEF, 4'h6);
    wait_idle();

    cur_tag = "R7";
    repeat (50) tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule